// File: doc/BRIEF.md
# DDR SDRAM Command Legality Checker

This block watches the command pins that a memory controller drives toward a four-bank DDR SDRAM and reports, one clock after each command, what the command was and whether it was legal given the present state of the banks. It decodes chip select, row strobe, column strobe, write enable, the clock-enable level in the previous and the current cycle, the two bank-select bits and the auto-precharge address bit into one command class. It then judges that class against a per-bank model of open, closed, bursting and recovering rows.

Each bank keeps its own small state machine and down-counter. A read or write with auto-precharge holds its bank for the burst (BURST_LEN/2 clocks), then for T_RP clocks of precharge recovery, and only then returns it to the closed state. A burst write with auto-precharge also blocks every read and write to any bank until its burst ends. A flagged command is reported but leaves the bank model untouched. This lets the checker run beside a scheduler under test and pinpoint the first bad command together with the rule it broke.

Top module: `ddr_cmd_checker`

## Requirements
- R1: With clock enable high in both the previous and the current cycle, chip select high decodes as DESEL (1). With chip select low, {ras_n,cas_n,we_n} decodes as follows: 000 MODE (2), 001 AREF (3), 011 ACT (6), 101 RD (7), 100 WR (8), 110 BST (9), 010 PRE (10, or PREA 11 when ap=1) and 111 NOP (0). The class appears on cmd_o, and {ba[1],ba[0]} appears on bank_o, one clock after the command is sampled.
- R2: A MODE command while any bank is not closed raises viol_o with reason_o=1.
- R3: An AREF, or a self-refresh entry, while any bank is not closed raises viol_o with reason_o=2.
- R4: Bank index is {ba[1],ba[0]}: 0 for bank A, 1 for bank B (ba[0] high alone), 2 for bank C (ba[1] high alone) and 3 for bank D. PRE with ap=0 closes only the open bank at that index. PRE with ap=1 ignores ba and closes every open bank.
- R5: ACT to a bank that is open or bursting gives reason_o=4. RD or WR to a bank that is not open gives reason_o=3.
- R6: RD or WR with ap=0 leaves the bank open. With ap=1 the bank is busy for the next BURST_LEN/2 commands, then recovering for the next T_RP commands, then closed.
- R7: During the busy window of a write with ap=1, any RD or WR to any bank gives reason_o=5, which takes priority over reason 3. Once that window ends, a RD or WR to another open bank is legal.
- R8: ACT to a bank in its recovery window gives reason_o=6. ACT in the first cycle after the window is legal.
- R9: BST is never flagged.
- R10: A clock enable that goes from high to low decodes as SR_IN (4) when the pins carry the AREF code, and as PD_IN (12) otherwise. A clock enable that goes from low to high decodes as SR_OUT (5) after an accepted self-refresh entry, and as PD_OUT (13) otherwise. A clock enable low in both cycles decodes as HOLD (14).
- R11: A command that raises viol_o changes no bank state.
- R12: After reset, cmd_o=0, viol_o=0 and reason_o=0. All banks are closed, and the previous clock enable is taken as high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable level this cycle |
| ba | input | 2 | Bank select, ba[0] is the low bit |
| ap | input | 1 | Auto-precharge / all-bank bit |
| cmd_o | output | 4 | Decoded command class |
| bank_o | output | 2 | Bank index of the command |
| viol_o | output | 1 | Command broke a sequencing rule |
| reason_o | output | 3 | Rule that was broken, 0 when legal |

## Verification
The hardest situation to reach is the edge of the auto-precharge windows: the cycle where a write burst's blocking ends and the cycle where a bank's recovery ends. Both exist only a fixed number of commands after the write and cannot be seen directly. The stimulus therefore issues a write with ap=1 and then places reads, writes and activates on every cycle offset across both windows, including an activate that is flagged and then repeated. A behavioural model records each window as absolute cycle numbers and predicts the reason code on each of those cycles.

// File: rtl/ddr_chk_pkg.sv
package ddr_chk_pkg;

    typedef enum logic [3:0] {
        CMD_NOP    = 4'd0,
        CMD_DESEL  = 4'd1,
        CMD_MODE   = 4'd2,
        CMD_AREF   = 4'd3,
        CMD_SR_IN  = 4'd4,
        CMD_SR_OUT = 4'd5,
        CMD_ACT    = 4'd6,
        CMD_RD     = 4'd7,
        CMD_WR     = 4'd8,
        CMD_BST    = 4'd9,
        CMD_PRE    = 4'd10,
        CMD_PREA   = 4'd11,
        CMD_PD_IN  = 4'd12,
        CMD_PD_OUT = 4'd13,
        CMD_HOLD   = 4'd14
    } cmd_e;

    typedef enum logic [2:0] {
        RSN_NONE        = 3'd0,
        RSN_MODE_OPEN   = 3'd1,
        RSN_REF_OPEN    = 3'd2,
        RSN_RW_CLOSED   = 3'd3,
        RSN_ACT_OPEN    = 3'd4,
        RSN_RW_IN_WAP   = 3'd5,
        RSN_ACT_RECOVER = 3'd6
    } rsn_e;

    typedef enum logic [1:0] {
        BK_IDLE    = 2'd0,
        BK_ACTIVE  = 2'd1,
        BK_BURST   = 2'd2,
        BK_RECOVER = 2'd3
    } bk_e;

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
    import ddr_chk_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic cke_prev,
    input  logic cke,
    input  logic ap,
    input  logic in_sref,
    output cmd_e cls_o
);

    logic [2:0] strobes;
    assign strobes = {ras_n, cas_n, we_n};

    always_comb begin
        cls_o = CMD_NOP;
        if (cke_prev && cke) begin
            if (cs_n) begin
                cls_o = CMD_DESEL;
            end else begin
                case (strobes)
                    3'b000:  cls_o = CMD_MODE;
                    3'b001:  cls_o = CMD_AREF;
                    3'b011:  cls_o = CMD_ACT;
                    3'b101:  cls_o = CMD_RD;
                    3'b100:  cls_o = CMD_WR;
                    3'b110:  cls_o = CMD_BST;
                    3'b010:  cls_o = ap ? CMD_PREA : CMD_PRE;
                    default: cls_o = CMD_NOP;
                endcase
            end
        end else if (cke_prev && !cke) begin
            cls_o = (!cs_n && strobes == 3'b001) ? CMD_SR_IN : CMD_PD_IN;
        end else if (!cke_prev && cke) begin
            cls_o = in_sref ? CMD_SR_OUT : CMD_PD_OUT;
        end else begin
            cls_o = CMD_HOLD;
        end
    end

endmodule

// File: rtl/ddr_bank_track.sv
module ddr_bank_track
    import ddr_chk_pkg::*;
#(
    parameter int BURST_CYC = 2,
    parameter int T_RP      = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_i,
    input  logic close_i,
    input  logic ap_i,
    input  logic ap_wr_i,
    output bk_e  state_o,
    output logic wap_o
);

    localparam int MAXC = (BURST_CYC > T_RP) ? BURST_CYC : T_RP;
    localparam int CW   = $clog2(MAXC + 1);

    typedef struct packed {
        bk_e         st;
        logic [CW-1:0] cnt;
        logic        wr;
    } bank_s;

    bank_s d, q;

    always_comb begin
        d = q;
        case (q.st)
            BK_IDLE: begin
                if (act_i) d.st = BK_ACTIVE;
            end
            BK_ACTIVE: begin
                if (ap_i) begin
                    d.st  = BK_BURST;
                    d.cnt = CW'(BURST_CYC);
                    d.wr  = ap_wr_i;
                end else if (close_i) begin
                    d.st = BK_IDLE;
                end
            end
            BK_BURST: begin
                if (q.cnt == CW'(1)) begin
                    d.st  = BK_RECOVER;
                    d.cnt = CW'(T_RP);
                    d.wr  = 1'b0;
                end else begin
                    d.cnt = q.cnt - CW'(1);
                end
            end
            default: begin
                if (q.cnt == CW'(1)) begin
                    d.st  = BK_IDLE;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt - CW'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: BK_IDLE, cnt: '0, wr: 1'b0};
        else        q <= d;
    end

    assign state_o = q.st;
    assign wap_o   = (q.st == BK_BURST) && q.wr;

    // R6: a timed window always holds a live count
    assert_cnt_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == BK_BURST || q.st == BK_RECOVER) |-> q.cnt != '0);

    // R6: a burst is only entered from an open row
    assert_burst_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == BK_BURST && $past(q.st) != BK_BURST) |-> $past(q.st) == BK_ACTIVE);

    // R8: recovery only ends by closing the bank
    assert_recover_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == BK_RECOVER) |=> (q.st == BK_RECOVER || q.st == BK_IDLE));

endmodule

// File: rtl/ddr_cmd_checker.sv
module ddr_cmd_checker
    import ddr_chk_pkg::*;
#(
    parameter int NBANK     = 4,
    parameter int BURST_LEN = 4,
    parameter int T_RP      = 3,
    localparam int BA_W     = $clog2(NBANK),
    localparam int BURST_CYC = BURST_LEN / 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n,
    input  logic            ras_n,
    input  logic            cas_n,
    input  logic            we_n,
    input  logic            cke,
    input  logic [BA_W-1:0] ba,
    input  logic            ap,
    output logic [3:0]      cmd_o,
    output logic [BA_W-1:0] bank_o,
    output logic            viol_o,
    output logic [2:0]      reason_o
);

    typedef struct packed {
        cmd_e            cmd;
        logic [BA_W-1:0] bank;
        logic            viol;
        rsn_e            rsn;
        logic            cke;
        logic            sref;
    } chk_s;

    chk_s d, q;
    cmd_e cls;
    rsn_e rsn;
    logic ok;
    logic all_idle, any_wap;
    logic [NBANK-1:0] idle_v, wap_v, act_ev, close_ev, ap_ev, sel;
    bk_e  st_v [NBANK];

    ddr_cmd_decode u_dec (
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .cke_prev (q.cke),
        .cke      (cke),
        .ap       (ap),
        .in_sref  (q.sref),
        .cls_o    (cls)
    );

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        ddr_bank_track #(.BURST_CYC(BURST_CYC), .T_RP(T_RP)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .act_i   (act_ev[g]),
            .close_i (close_ev[g]),
            .ap_i    (ap_ev[g]),
            .ap_wr_i (cls == CMD_WR),
            .state_o (st_v[g]),
            .wap_o   (wap_v[g])
        );
        assign idle_v[g] = (st_v[g] == BK_IDLE);
    end

    assign all_idle = &idle_v;
    assign any_wap  = |wap_v;
    assign sel      = NBANK'(1) << ba;

    always_comb begin
        d        = q;
        rsn      = RSN_NONE;
        act_ev   = '0;
        close_ev = '0;
        ap_ev    = '0;
        case (cls)
            CMD_MODE: if (!all_idle) rsn = RSN_MODE_OPEN;
            CMD_AREF, CMD_SR_IN: if (!all_idle) rsn = RSN_REF_OPEN;
            CMD_RD, CMD_WR: begin
                if (any_wap)                     rsn = RSN_RW_IN_WAP;
                else if (st_v[ba] != BK_ACTIVE)  rsn = RSN_RW_CLOSED;
            end
            CMD_ACT: begin
                if (st_v[ba] == BK_RECOVER)      rsn = RSN_ACT_RECOVER;
                else if (st_v[ba] != BK_IDLE)    rsn = RSN_ACT_OPEN;
            end
            default: ;
        endcase
        ok = (rsn == RSN_NONE);
        if (ok) begin
            case (cls)
                CMD_ACT:        act_ev   = sel;
                CMD_RD, CMD_WR: ap_ev    = ap ? sel : '0;
                CMD_PRE:        close_ev = sel;
                CMD_PREA:       close_ev = '1;
                default: ;
            endcase
        end
        if (cls == CMD_SR_IN && ok)                     d.sref = 1'b1;
        else if (cls == CMD_SR_OUT || cls == CMD_PD_OUT) d.sref = 1'b0;
        d.cmd  = cls;
        d.bank = ba;
        d.rsn  = rsn;
        d.viol = !ok;
        d.cke  = cke;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{cmd: CMD_NOP, bank: '0, viol: 1'b0, rsn: RSN_NONE, cke: 1'b1, sref: 1'b0};
        else        q <= d;
    end

    assign cmd_o    = q.cmd;
    assign bank_o   = q.bank;
    assign viol_o   = q.viol;
    assign reason_o = q.rsn;

    // R2: an accepted mode set saw every bank closed
    assert_mode_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cmd == CMD_MODE && !q.viol) |-> $past(all_idle));

    // R5: an accepted activate targeted a closed bank
    assert_act_closed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cmd == CMD_ACT && !q.viol) |-> $past(idle_v[ba]));

    // R9: burst stop is never flagged
    assert_bst_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cmd == CMD_BST) |-> !q.viol);

    // R11: a flagged command sent no event to any bank
    assert_flag_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
        q.viol |-> ($past(act_ev) == '0 && $past(close_ev) == '0 && $past(ap_ev) == '0));

endmodule

// File: tb/sim_ddr_cmd_checker.sv
`timescale 1ns/1ps
module sim_ddr_cmd_checker;

    localparam int BL  = 4;
    localparam int BC  = BL / 2;
    localparam int TRP = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1, ap = 1'b0;
    logic [1:0] ba = 2'd0;
    logic [3:0] cmd_o;
    logic [1:0] bank_o;
    logic       viol_o;
    logic [2:0] reason_o;

    int errors = 0;
    int checks = 0;
    int edge_n = 0;
    bit done = 0;

    // behavioural model: 0 closed, 1 open, 2 auto-precharge pending
    int mst  [4];
    int bend [4];
    int rdy  [4];
    int mwr  [4];
    bit m_cke = 1;
    bit m_sref = 0;

    always #2 clk = ~clk;

    ddr_cmd_checker #(.NBANK(4), .BURST_LEN(BL), .T_RP(TRP)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .cke(cke), .ba(ba), .ap(ap),
        .cmd_o(cmd_o), .bank_o(bank_o), .viol_o(viol_o), .reason_o(reason_o)
    );

    function automatic int view(int k, int e);
        if (mst[k] == 2) begin
            if (e <= bend[k]) return 2;
            if (e <= rdy[k])  return 3;
            return 0;
        end
        return mst[k];
    endfunction

    function automatic string tag_of(int c, int r);
        case (r)
            1: return "R2";
            2: return "R3";
            3, 4: return "R5";
            5: return "R7";
            6: return "R8";
            default: ;
        endcase
        case (c)
            9: return "R9";
            10, 11: return "R4";
            4, 5, 12, 13, 14: return "R10";
            7, 8: return "R6";
            default: return "R1";
        endcase
    endfunction

    task automatic check(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic c, r, ca, w, ck, input logic [1:0] b, input logic a,
                        input string tag = "");
        int e, ec, er, all_idle, any_wap;
        string t;
        @(negedge clk);
        cs_n = c; ras_n = r; cas_n = ca; we_n = w; cke = ck; ba = b; ap = a;
        e = edge_n + 1;
        for (int k = 0; k < 4; k++) if (view(k, e) == 0) mst[k] = 0;
        if (m_cke && ck) begin
            if (c) ec = 1;
            else case ({r, ca, w})
                3'b000: ec = 2;
                3'b001: ec = 3;
                3'b011: ec = 6;
                3'b101: ec = 7;
                3'b100: ec = 8;
                3'b110: ec = 9;
                3'b010: ec = a ? 11 : 10;
                default: ec = 0;
            endcase
        end else if (m_cke && !ck) ec = (!c && {r, ca, w} == 3'b001) ? 4 : 12;
        else if (!m_cke && ck) ec = m_sref ? 5 : 13;
        else ec = 14;
        all_idle = 1; any_wap = 0;
        for (int k = 0; k < 4; k++) begin
            if (view(k, e) != 0) all_idle = 0;
            if (view(k, e) == 2 && mwr[k] != 0) any_wap = 1;
        end
        er = 0;
        if (ec == 2 && !all_idle) er = 1;
        if ((ec == 3 || ec == 4) && !all_idle) er = 2;
        if (ec == 7 || ec == 8) er = any_wap ? 5 : (view(b, e) != 1 ? 3 : 0);
        if (ec == 6) er = (view(b, e) == 3) ? 6 : (view(b, e) != 0 ? 4 : 0);
        @(posedge clk);
        edge_n++;
        #1;
        t = (tag != "") ? tag : tag_of(ec, er);
        check(t, int'(cmd_o), ec, "cmd");
        check(t, int'(bank_o), int'(b), "bank");
        check(t, int'(viol_o), (er != 0) ? 1 : 0, "viol");
        check(t, int'(reason_o), er, "reason");
        if (er == 0) begin
            case (ec)
                6: mst[b] = 1;
                7, 8: if (a) begin
                    mst[b] = 2; bend[b] = e + BC; rdy[b] = e + BC + TRP;
                    mwr[b] = (ec == 8) ? 1 : 0;
                end
                10: if (view(b, e) == 1) mst[b] = 0;
                11: for (int k = 0; k < 4; k++) if (view(k, e) == 1) mst[k] = 0;
                4: m_sref = 1;
                default: ;
            endcase
        end
        if (ec == 5 || ec == 13) m_sref = 0;
        m_cke = ck;
    endtask

    task automatic nop(string t = "");                  step(0,1,1,1,1,2'd0,0,t); endtask
    task automatic act(logic [1:0] b, string t = "");   step(0,0,1,1,1,b,0,t);    endtask
    task automatic rd(logic [1:0] b, logic a, string t = ""); step(0,1,0,1,1,b,a,t); endtask
    task automatic wr(logic [1:0] b, logic a, string t = ""); step(0,1,0,0,1,b,a,t); endtask
    task automatic pre(logic [1:0] b, string t = "");   step(0,0,1,0,1,b,0,t);    endtask
    task automatic prea(logic [1:0] b = 2'd2);          step(0,0,1,0,1,b,1,"R4"); endtask

    initial begin
        for (int k = 0; k < 4; k++) begin mst[k] = 0; bend[k] = 0; rdy[k] = 0; mwr[k] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R12", int'(cmd_o), 0, "reset cmd");
        check("R12", int'(viol_o), 0, "reset viol");
        check("R12", int'(reason_o), 0, "reset reason");
        // R1 decode of idle codes and legal mode set
        nop("R1");
        step(1,0,0,0,1,2'd3,0,"R1");
        step(0,0,0,0,1,2'd1,0,"R1");
        // R2/R3/R5 with bank A open
        act(2'd0);
        step(0,0,0,0,1,2'd0,0);
        step(0,0,0,1,1,2'd0,0);
        act(2'd0);
        rd(2'd1, 0);
        rd(2'd0, 0, "R6");
        wr(2'd0, 0, "R6");
        rd(2'd0, 0, "R6");
        step(0,1,1,0,1,2'd0,0);
        pre(2'd0, "R4");
        rd(2'd0, 0, "R5");
        // R4 bank index and all-bank precharge
        act(2'd1); act(2'd2); act(2'd3);
        wr(2'd3, 0, "R4");
        pre(2'd2, "R4");
        wr(2'd2, 0, "R4");
        prea(2'd0);
        rd(2'd1, 0, "R4");
        rd(2'd3, 0, "R4");
        step(0,0,0,1,1,2'd0,0,"R3");
        // R7/R8 write with auto-precharge windows
        act(2'd0); act(2'd1);
        wr(2'd0, 1, "R6");
        rd(2'd1, 0, "R7");
        wr(2'd1, 0, "R7");
        rd(2'd1, 0, "R7");
        act(2'd0, "R8");
        act(2'd0, "R8");
        act(2'd0, "R8");
        rd(2'd0, 0, "R6");
        // R11 flagged activate left state alone
        act(2'd0, "R11");
        pre(2'd0);
        rd(2'd0, 0, "R11");
        // read with auto-precharge does not block other banks
        rd(2'd1, 1, "R6");
        wr(2'd2, 0, "R5");
        act(2'd1, "R5");
        act(2'd2);
        wr(2'd2, 0, "R7");
        repeat (4) nop();
        act(2'd1, "R8");
        prea();
        // R10 self refresh and power down
        step(0,0,0,1,0,2'd0,0,"R10");
        step(1,1,1,1,0,2'd0,0,"R10");
        step(1,1,1,1,1,2'd0,0,"R10");
        act(2'd0);
        step(0,1,1,1,0,2'd0,0,"R10");
        step(1,1,1,1,1,2'd0,0,"R10");
        step(0,0,0,1,0,2'd0,0,"R3");
        step(1,1,1,1,0,2'd0,0,"R10");
        step(1,1,1,1,1,2'd0,0,"R10");
        step(0,1,1,0,1,2'd3,0,"R9");
        nop();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule